// File: doc/BRIEF.md
# Multi-Channel Peripheral DMA Controller

This block moves data between memory and peripheral FIFOs on behalf of software. It has a set of independent channels that share one bus master. Software programs each channel through a 32-bit register port with a source address, a destination address, a segment length and a burst size. It then releases the channel. The shared engine copies each 32-bit word by reading the source and writing the destination. Either side can stay on one fixed address, which is how a peripheral FIFO is addressed. A side bound to a peripheral request line waits for that line before each burst. When the burst ends, that side returns a one-cycle acknowledge.

When a channel's segment is exhausted, the channel switches itself off and raises its done flag. If its done interrupt is enabled, the interrupt line goes high. Software clears status flags by writing ones. A global register chooses between lowest-number-first and rotating arbitration among the channels that are ready. It also reports the block version and the channel-count code.

Top module: `dmac_top`

## Requirements
- R1: After reset, every channel register, the done register (0x204) and the started register (0x200) read 0, and `mem_req`, `per_ack` and `irq` are low. The global register (0x220) reads 0x0A with the defaults: bit 0 is round-robin (0), bits 2:1 are version 1, and bits 4:3 are channel-count code 1 (count = 8 << code).
- R2: Channel n occupies byte offsets n*16 + 0x0 (source address), +0x4 (destination address), +0x8 (control A) and +0xC (control B). Writes to the source address, destination address and control B read back unchanged while the channel is idle.
- R3: Control A bits 31:16 hold the segment length in bytes. Bits 4:3 hold the burst code c (bit 5 reads 0). Writing control A with bit 1 set loads the remaining-burst count with length >> (2+c). Bits 15:8 read back the low 8 bits of that count, and the count drops by one after every finished burst.
- R4: Burst code c gives 2^c word beats per burst (4, 8, 16 or 32 bytes). Each beat reads the source and then writes the read data to the destination. The source and destination addresses advance by 4 after each beat unless control A bit 7 (source fixed) or bit 6 (destination fixed) holds that address. Software sees the advanced addresses.
- R5: A channel whose enable bit (control A bit 1) is set does not issue bus requests while control B bit 0 (hold) is 1. Clearing the hold bit lets the channel start.
- R6: A control B request number (source in bits 21:16, destination in bits 13:8) of 32 or above marks an unpaced memory side. A number n below 32 makes the channel wait for `per_req[n]` before each burst, and `per_ack[n]` pulses high for exactly one cycle after the burst's last write.
- R7: When the count reaches zero, the channel clears its own enable bit and sets its bit in the done register. `irq` goes high while any done bit is set whose channel has control A bit 2 set, and it stays low otherwise.
- R8: Writing a one to a bit of the done register or the started register clears that bit, and writing a zero leaves it unchanged. A channel's started bit is set when the channel is granted its first burst.
- R9: Writing control A of the active channel with bit 1 clear stops it at once. No bus request follows, and the done bit stays clear.
- R10: With global bit 0 clear, the lowest-numbered ready channel wins. With the bit set, the search starts at the channel after the last one granted. A new grant is made only between bursts.
- R11: While `mem_req` is high and `mem_gnt` is low, `mem_addr` and `mem_we` hold their values. A read beat completes in the cycle where `mem_gnt` is high, with `mem_rdata` valid in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; data appears on `reg_rdata` after the next edge |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| mem_req | output | 1 | Bus master request |
| mem_we | output | 1 | 1 for a write beat, 0 for a read beat |
| mem_addr | output | 32 | Bus byte address |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Beat accepted in this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_gnt` |
| per_req | input | NUM_REQ | Peripheral request lines |
| per_ack | output | NUM_REQ | One-cycle burst acknowledges |
| irq | output | 1 | Done interrupt |

## Verification
Properties watched on every cycle cover the bus handshake, the single-cycle acknowledge pulses and the ordering of each burst (read first). They also check that the active channel is still enabled whenever a request is out, and that the live burst count never rises during a transfer. The bench scenarios are the only place to observe the things that need a whole transfer: the exact address and data sequence for each burst size and fixed-address mode, hold gating, pacing stalls, abort, the write-one-to-clear flags, and which channel wins under each arbitration mode.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  localparam logic [11:0] OFS_STARTED = 12'h200;
  localparam logic [11:0] OFS_DONE    = 12'h204;
  localparam logic [11:0] OFS_GLOBAL  = 12'h220;

  typedef enum logic [1:0] {ENG_IDLE, ENG_READ, ENG_WRITE} eng_state_e;

  // register slot inside a channel window
  typedef enum logic [1:0] {SLOT_SRC, SLOT_DST, SLOT_CTLA, SLOT_CTLB} slot_e;
endpackage

// File: rtl/dmac_arbiter.sv
module dmac_arbiter #(
  parameter int N  = 16,
  parameter int CW = $clog2(N)
) (
  input  logic [N-1:0]  ready,
  input  logic          rotate,
  input  logic [CW-1:0] last,
  output logic          found,
  output logic [CW-1:0] pick
);
  logic [CW-1:0] base;
  logic [CW-1:0] cand;

  always_comb begin
    base  = rotate ? last + CW'(1) : '0;
    found = 1'b0;
    pick  = '0;
    cand  = '0;
    for (int k = 0; k < N; k++) begin
      cand = base + CW'(k);
      if (!found && ready[cand]) begin
        found = 1'b1;
        pick  = cand;
      end
    end
  end
endmodule

// File: rtl/dmac_chan.sv
module dmac_chan #(
  parameter int AW    = 32,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_src,
  input  logic             wr_dst,
  input  logic             wr_ctla,
  input  logic             wr_ctlb,
  input  logic [31:0]      wdata,
  input  logic             beat_done,
  input  logic             burst_done,
  output logic [AW-1:0]    src_q,
  output logic [AW-1:0]    dst_q,
  output logic [31:0]      ctla_rd,
  output logic [31:0]      ctlb_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic [1:0]       code_q,
  output logic             en_q,
  output logic             ie_q,
  output logic             runnable,
  output logic             finish
);
  logic [15:0] len_q;
  logic        fix_src_q, fix_dst_q;
  logic        unused_bits;

  assign unused_bits = ^{wdata[15:8], wdata[5], wdata[0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q <= '0; dst_q <= '0; ctlb_q <= '0; cnt_q <= '0; len_q <= '0;
      code_q <= '0; en_q <= 1'b0; ie_q <= 1'b0; fix_src_q <= 1'b0; fix_dst_q <= 1'b0;
    end else begin
      if (wr_src)                      src_q <= wdata[AW-1:0];
      else if (beat_done && !fix_src_q) src_q <= src_q + AW'(4);
      if (wr_dst)                      dst_q <= wdata[AW-1:0];
      else if (beat_done && !fix_dst_q) dst_q <= dst_q + AW'(4);
      if (wr_ctlb) ctlb_q <= wdata;
      if (wr_ctla) begin
        len_q     <= wdata[31:16];
        fix_src_q <= wdata[7];
        fix_dst_q <= wdata[6];
        code_q    <= wdata[4:3];
        ie_q      <= wdata[2];
        en_q      <= wdata[1];
        if (wdata[1]) cnt_q <= CNT_W'(wdata[31:16] >> (2 + wdata[4:3]));
      end else if (burst_done) begin
        cnt_q <= cnt_q - CNT_W'(1);
        if (cnt_q == CNT_W'(1)) en_q <= 1'b0;
      end
    end
  end

  assign finish   = burst_done && !wr_ctla && (cnt_q == CNT_W'(1));
  assign runnable = en_q && !ctlb_q[0] && (cnt_q != '0);
  assign ctla_rd  = {len_q, cnt_q[7:0], fix_src_q, fix_dst_q, 1'b0, code_q, ie_q, en_q, 1'b0};
endmodule

// File: rtl/dmac_top.sv
module dmac_top #(
  parameter int         NUM_CH  = 16,
  parameter int         NUM_REQ = 32,
  parameter int         CNT_W   = 16,
  parameter logic [1:0] VERSION = 2'd1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [11:0]        reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic               mem_req,
  output logic               mem_we,
  output logic [31:0]        mem_addr,
  output logic [31:0]        mem_wdata,
  input  logic               mem_gnt,
  input  logic [31:0]        mem_rdata,
  input  logic [NUM_REQ-1:0] per_req,
  output logic [NUM_REQ-1:0] per_ack,
  output logic               irq
);
  import dmac_pkg::*;

  localparam int         CW      = $clog2(NUM_CH);
  localparam int         RQ_W    = $clog2(NUM_REQ);
  localparam int         CH_SPAN = NUM_CH * 16;
  localparam logic [1:0] CH_CODE = 2'($clog2(NUM_CH / 8));

  // register decode
  logic          ch_hit;
  logic [CW-1:0] addr_ch;
  slot_e         slot;
  assign ch_hit  = (32'(reg_addr) < 32'(CH_SPAN)) && (reg_addr[1:0] == 2'b00);
  assign addr_ch = reg_addr[CW+3:4];
  assign slot    = slot_e'(reg_addr[3:2]);

  // per-channel state
  logic [31:0]      src_arr  [NUM_CH];
  logic [31:0]      dst_arr  [NUM_CH];
  logic [31:0]      ctla_arr [NUM_CH];
  logic [31:0]      ctlb_arr [NUM_CH];
  logic [CNT_W-1:0] cnt_arr  [NUM_CH];
  logic [1:0]       code_arr [NUM_CH];
  logic [5:0]       srcn_arr [NUM_CH];
  logic [5:0]       dstn_arr [NUM_CH];
  logic [NUM_CH-1:0] en_vec, ie_vec, run_vec, fin_vec, ready_vec, src_free, dst_free;

  // engine state
  eng_state_e    state_q;
  logic [CW-1:0] cur_q, last_q;
  logic [2:0]    beat_q;
  logic [31:0]   hold_q;
  logic          rotate_q;
  logic [NUM_CH-1:0] done_q, started_q;
  logic [NUM_REQ-1:0] ack_q, ack_vec;
  logic [31:0]   rdata_q;
  logic          irq_q;

  logic          arb_found;
  logic [CW-1:0] arb_pick;
  logic          kill, beat_fire, burst_fire, cur_en;
  logic [CNT_W-1:0] cnt_cur;
  logic          unused_top;

  assign unused_top = ^reg_wdata;

  assign cur_en  = en_vec[cur_q];
  assign cnt_cur = cnt_arr[cur_q];
  assign kill    = !cur_en || (reg_wr && ch_hit && (addr_ch == cur_q) &&
                               (slot == SLOT_CTLA) && !reg_wdata[1]);
  assign beat_fire  = (state_q == ENG_WRITE) && mem_gnt && !kill;
  assign burst_fire = beat_fire && (beat_q == 3'd0);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic sel_i;
    assign sel_i = reg_wr && ch_hit && (addr_ch == CW'(i));

    dmac_chan #(.AW(32), .CNT_W(CNT_W)) u_chan (
      .clk       (clk),
      .rst       (rst),
      .wr_src    (sel_i && slot == SLOT_SRC),
      .wr_dst    (sel_i && slot == SLOT_DST),
      .wr_ctla   (sel_i && slot == SLOT_CTLA),
      .wr_ctlb   (sel_i && slot == SLOT_CTLB),
      .wdata     (reg_wdata),
      .beat_done (beat_fire && (cur_q == CW'(i))),
      .burst_done(burst_fire && (cur_q == CW'(i))),
      .src_q     (src_arr[i]),
      .dst_q     (dst_arr[i]),
      .ctla_rd   (ctla_arr[i]),
      .ctlb_q    (ctlb_arr[i]),
      .cnt_q     (cnt_arr[i]),
      .code_q    (code_arr[i]),
      .en_q      (en_vec[i]),
      .ie_q      (ie_vec[i]),
      .runnable  (run_vec[i]),
      .finish    (fin_vec[i])
    );

    assign srcn_arr[i]  = ctlb_arr[i][21:16];
    assign dstn_arr[i]  = ctlb_arr[i][13:8];
    assign src_free[i]  = (32'(srcn_arr[i]) >= NUM_REQ) || per_req[srcn_arr[i][RQ_W-1:0]];
    assign dst_free[i]  = (32'(dstn_arr[i]) >= NUM_REQ) || per_req[dstn_arr[i][RQ_W-1:0]];
    assign ready_vec[i] = run_vec[i] && src_free[i] && dst_free[i];

    always_ff @(posedge clk) begin
      if (rst) begin
        done_q[i]    <= 1'b0;
        started_q[i] <= 1'b0;
      end else begin
        if (fin_vec[i]) done_q[i] <= 1'b0 | 1'b1;
        else if (reg_wr && reg_addr == OFS_DONE && reg_wdata[i]) done_q[i] <= 1'b0;
        if (state_q == ENG_IDLE && arb_found && arb_pick == CW'(i)) started_q[i] <= 1'b1;
        else if (reg_wr && reg_addr == OFS_STARTED && reg_wdata[i]) started_q[i] <= 1'b0;
      end
    end
  end

  dmac_arbiter #(.N(NUM_CH), .CW(CW)) u_arb (
    .ready (ready_vec),
    .rotate(rotate_q),
    .last  (last_q),
    .found (arb_found),
    .pick  (arb_pick)
  );

  // acknowledge lines of the active channel's paced sides
  always_comb begin
    ack_vec = '0;
    if (32'(srcn_arr[cur_q]) < NUM_REQ) ack_vec[srcn_arr[cur_q][RQ_W-1:0]] = 1'b1;
    if (32'(dstn_arr[cur_q]) < NUM_REQ) ack_vec[dstn_arr[cur_q][RQ_W-1:0]] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ENG_IDLE; cur_q <= '0; last_q <= '0; beat_q <= '0;
      hold_q <= '0; ack_q <= '0;
    end else begin
      ack_q <= '0;
      unique case (state_q)
        ENG_IDLE: if (arb_found) begin
          cur_q   <= arb_pick;
          last_q  <= arb_pick;
          beat_q  <= 3'((4'd1 << code_arr[arb_pick]) - 4'd1);
          state_q <= ENG_READ;
        end
        ENG_READ: if (kill) state_q <= ENG_IDLE;
          else if (mem_gnt) begin
            hold_q  <= mem_rdata;
            state_q <= ENG_WRITE;
          end
        ENG_WRITE: if (kill) state_q <= ENG_IDLE;
          else if (mem_gnt) begin
            if (beat_q == 3'd0) begin
              state_q <= ENG_IDLE;
              ack_q   <= ack_vec;
            end else begin
              beat_q  <= beat_q - 3'd1;
              state_q <= ENG_READ;
            end
          end
        default: state_q <= ENG_IDLE;
      endcase
    end
  end

  // global register, read port, interrupt
  always_ff @(posedge clk) begin
    if (rst) begin
      rotate_q <= 1'b0; rdata_q <= '0; irq_q <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == OFS_GLOBAL) rotate_q <= reg_wdata[0];
      irq_q <= |(done_q & ie_vec);
      if (reg_rd) begin
        if (ch_hit) begin
          unique case (slot)
            SLOT_SRC:  rdata_q <= src_arr[addr_ch];
            SLOT_DST:  rdata_q <= dst_arr[addr_ch];
            SLOT_CTLA: rdata_q <= ctla_arr[addr_ch];
            default:   rdata_q <= ctlb_arr[addr_ch];
          endcase
        end else if (reg_addr == OFS_DONE)    rdata_q <= 32'(done_q);
        else if (reg_addr == OFS_STARTED)     rdata_q <= 32'(started_q);
        else if (reg_addr == OFS_GLOBAL)      rdata_q <= {27'd0, CH_CODE, VERSION, rotate_q};
        else                                  rdata_q <= '0;
      end
    end
  end

  assign reg_rdata = rdata_q;
  assign mem_req   = (state_q != ENG_IDLE);
  assign mem_we    = (state_q == ENG_WRITE);
  assign mem_addr  = (state_q == ENG_WRITE) ? dst_arr[cur_q] : src_arr[cur_q];
  assign mem_wdata = hold_q;
  assign per_ack   = ack_q;
  assign irq       = irq_q;
endmodule

// File: rtl/dmac_checker.sv
module dmac_checker #(
  parameter int NUM_REQ = 32,
  parameter int CNT_W   = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               mem_req,
  input logic               mem_we,
  input logic               mem_gnt,
  input logic [31:0]        mem_addr,
  input logic [NUM_REQ-1:0] per_ack,
  input logic               reg_wr,
  input logic               cur_en,
  input logic [CNT_W-1:0]   cnt_cur
);
  // R6: an acknowledge line never stays high two cycles in a row
  assert_ack_single_R6: assert property (@(posedge clk) disable iff (rst)
    (|per_ack) |=> ((per_ack & $past(per_ack)) == '0));

  // R11: a stalled request keeps address and direction
  assert_bus_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_gnt) |=> (!mem_req || ($stable(mem_addr) && $stable(mem_we))));

  // R4: every burst opens with a read beat
  assert_read_first_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_req) |-> !mem_we);

  // R9: no request is out for a channel whose enable is clear
  assert_enabled_R9: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> cur_en);

  // R3: the live count of the active channel never rises during a transfer
  assert_count_down_R3: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !reg_wr) |=> (cnt_cur <= $past(cnt_cur)));
endmodule

bind dmac_top dmac_checker #(.NUM_REQ(NUM_REQ), .CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .mem_req (mem_req),
  .mem_we  (mem_we),
  .mem_gnt (mem_gnt),
  .mem_addr(mem_addr),
  .per_ack (per_ack),
  .reg_wr  (reg_wr),
  .cur_en  (cur_en),
  .cnt_cur (cnt_cur)
);

// File: tb/test_dmac_top.sv
`timescale 1ns/1ps
module test_dmac_top;
  localparam int NUM_REQ = 32;
  localparam logic [31:0] KEY = 32'h5A5A_0000;

  typedef struct packed {
    logic [3:0]  ch;
    logic [31:0] src;
    logic [31:0] dst;
    logic [15:0] len;
    logic [1:0]  code;
    logic        fs;
    logic        fd;
    logic        ie;
    logic        stall;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{4'd0,  32'h0000_1000, 32'h0000_8000, 16'd16, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0},
    '{4'd5,  32'h0000_2000, 32'h0000_9000, 16'd32, 2'd1, 1'b0, 1'b1, 1'b0, 1'b1},
    '{4'd15, 32'h0000_3000, 32'h0000_A000, 16'd64, 2'd2, 1'b1, 1'b0, 1'b1, 1'b0},
    '{4'd9,  32'h0000_4000, 32'h0000_B000, 16'd96, 2'd3, 1'b0, 1'b0, 1'b1, 1'b1},
    '{4'd2,  32'h0000_5000, 32'h0000_C000, 16'd4,  2'd0, 1'b0, 1'b0, 1'b0, 1'b0}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic mem_req, mem_we, mem_gnt = 1'b1;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [NUM_REQ-1:0] per_req = '0, per_ack;
  logic irq;

  int n_cmp = 0, n_err = 0, beats = 0;
  logic stall = 1'b0, chk_en = 1'b0, first_seen = 1'b0, mon_fs = 1'b0, mon_fd = 1'b0;
  logic [31:0] exp_src = '0, exp_dst = '0, first_dst = '0;

  always #2.5 clk = ~clk;

  assign mem_rdata = mem_addr ^ KEY;

  dmac_top i_dmac_top (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
    .per_req(per_req), .per_ack(per_ack), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
  endtask

  always @(posedge clk) begin
    #1;
    mem_gnt <= stall ? ~mem_gnt : 1'b1;
  end

  // write-beat monitor, sampled mid-cycle (R4)
  always @(negedge clk) begin
    if (!rst && mem_req && mem_we && mem_gnt) begin
      beats++;
      if (!first_seen) begin first_seen = 1'b1; first_dst = mem_addr; end
      if (chk_en) begin
        chk("R4 write address", mem_addr, exp_dst);
        chk("R4 write data", mem_wdata, exp_src ^ KEY);
        if (!mon_fs) exp_src += 32'd4;
        if (!mon_fd) exp_dst += 32'd4;
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic wait_done(input logic [31:0] m);
    logic [31:0] d;
    for (int k = 0; k < 3000; k++) begin
      rd(12'h204, d);
      if ((d & m) == m) break;
    end
  endtask

  function automatic logic [31:0] ctla(input logic [15:0] len, input logic [7:0] cnt,
      input logic fs, input logic fd, input logic [1:0] code, input logic ie, input logic en);
    return {len, cnt, fs, fd, 1'b0, code, ie, en, 1'b0};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog R7: actual run still busy expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] d;
    int b0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1 reset state
    chk("R1 mem_req", 32'(mem_req), 32'd0);
    chk("R1 irq", 32'(irq), 32'd0);
    chk("R1 per_ack", per_ack, 32'd0);
    rd(12'h008, d); chk("R1 ctla ch0", d, 32'd0);
    rd(12'h204, d); chk("R1 done reg", d, 32'd0);
    rd(12'h200, d); chk("R1 started reg", d, 32'd0);
    rd(12'h220, d); chk("R1 global reg", d, 32'h0000_000A);

    // table of transfers
    for (int v = 0; v < 5; v++) begin
      vec_t t;
      logic [11:0] base;
      logic [7:0] c8;
      t = VECS[v];
      base = {t.ch, 4'h0};
      c8 = 8'(t.len >> (2 + t.code));
      stall = t.stall; mon_fs = t.fs; mon_fd = t.fd;
      exp_src = t.src; exp_dst = t.dst; chk_en = 1'b1;
      b0 = beats;
      wr(base + 12'h0, t.src);
      wr(base + 12'h4, t.dst);
      wr(base + 12'hC, 32'h0020_2001);
      rd(base + 12'h0, d); chk("R2 src readback", d, t.src);
      rd(base + 12'h4, d); chk("R2 dst readback", d, t.dst);
      rd(base + 12'hC, d); chk("R2 ctlb readback", d, 32'h0020_2001);
      wr(base + 12'h8, ctla(t.len, 8'h0, t.fs, t.fd, t.code, t.ie, 1'b1));
      repeat (5) @(negedge clk);
      chk("R5 held channel idle", 32'(beats - b0), 32'd0);
      rd(base + 12'h8, d); chk("R3 loaded count", d, ctla(t.len, c8, t.fs, t.fd, t.code, t.ie, 1'b1));
      wr(base + 12'hC, 32'h0020_2000);
      wait_done(32'd1 << t.ch);
      chk("R4 beat total", 32'(beats - b0), 32'(t.len / 4));
      rd(base + 12'h8, d); chk("R7 enable and count cleared", d, ctla(t.len, 8'h0, t.fs, t.fd, t.code, t.ie, 1'b0));
      rd(base + 12'h0, d); chk("R4 src advanced", d, t.src + (t.fs ? 32'd0 : 32'(t.len)));
      rd(base + 12'h4, d); chk("R4 dst advanced", d, t.dst + (t.fd ? 32'd0 : 32'(t.len)));
      repeat (2) @(negedge clk);
      chk("R7 irq follows done enable", 32'(irq), 32'(t.ie));
      rd(12'h200, d); chk("R8 started bit", d, 32'd1 << t.ch);
      wr(12'h204, 32'd1 << t.ch);
      wr(12'h200, 32'd1 << t.ch);
      repeat (2) @(negedge clk);
      chk("R7 irq after clear", 32'(irq), 32'd0);
      rd(12'h204, d); chk("R8 done cleared", d, 32'd0);
      chk_en = 1'b0;
    end
    stall = 1'b0;

    // R5 hold bit keeps an enabled channel idle
    b0 = beats;
    wr(12'h060, 32'h0000_6000); wr(12'h064, 32'h0000_E000);
    wr(12'h06C, 32'h0020_2001);
    wr(12'h068, ctla(16'd8, 8'h0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1));
    repeat (30) @(negedge clk);
    chk("R5 no beats while held", 32'(beats - b0), 32'd0);
    rd(12'h200, d); chk("R5 not started while held", d, 32'd0);
    wr(12'h06C, 32'h0020_2000);
    wait_done(32'h40);
    chk("R5 runs after release", 32'(beats - b0), 32'd2);
    wr(12'h204, 32'h40); wr(12'h200, 32'h40);

    // R6 pacing on destination request 5, R3 live count
    b0 = beats;
    wr(12'h070, 32'h0000_7000); wr(12'h074, 32'h0000_F000);
    wr(12'h07C, 32'h0020_0500);
    wr(12'h078, ctla(16'd16, 8'h0, 1'b0, 1'b1, 2'd0, 1'b0, 1'b1));
    repeat (20) @(negedge clk);
    chk("R6 waits for request", 32'(beats - b0), 32'd0);
    for (int k = 0; k < 4; k++) begin
      per_req[5] = 1'b1;
      for (int w = 0; w < 100; w++) begin
        @(negedge clk);
        if (per_ack[5]) break;
      end
      per_req[5] = 1'b0;
      chk("R6 ack seen", 32'(per_ack), 32'h20);
      @(negedge clk);
      chk("R6 ack one cycle", 32'(per_ack[5]), 32'd0);
      chk("R6 one burst per request", 32'(beats - b0), 32'(k + 1));
      if (k == 0) begin
        rd(12'h078, d); chk("R3 live count", 32'(d[15:8]), 32'd3);
      end
    end
    wait_done(32'h80);

    // R8 write-one-to-clear behaviour
    wr(12'h204, 32'h0000_0040);
    rd(12'h204, d); chk("R8 zero bit keeps done", d, 32'h80);
    wr(12'h204, 32'h80);
    rd(12'h204, d); chk("R8 one clears done", d, 32'd0);
    rd(12'h200, d); chk("R8 started set", d, 32'h80);
    wr(12'h200, 32'h80);
    rd(12'h200, d); chk("R8 one clears started", d, 32'd0);

    // R9 abort of an active channel
    wr(12'h040, 32'h0001_0000); wr(12'h044, 32'h0002_0000);
    wr(12'h04C, 32'h0020_2000);
    wr(12'h048, ctla(16'd1024, 8'h0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1));
    repeat (10) @(negedge clk);
    wr(12'h048, ctla(16'd1024, 8'h0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0));
    repeat (2) @(negedge clk);
    b0 = beats;
    chk("R9 request dropped", 32'(mem_req), 32'd0);
    repeat (30) @(negedge clk);
    chk("R9 no beats after stop", 32'(beats - b0), 32'd0);
    rd(12'h204, d); chk("R9 done stays clear", d, 32'd0);
    wr(12'h200, 32'hFFFF);

    // R10 fixed priority: channels 3 and 1 on request 7
    wr(12'h010, 32'h0000_0100); wr(12'h014, 32'h0000_D100); wr(12'h01C, 32'h0020_0700);
    wr(12'h030, 32'h0000_0300); wr(12'h034, 32'h0000_D300); wr(12'h03C, 32'h0020_0700);
    wr(12'h038, ctla(16'd4, 8'h0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1));
    wr(12'h018, ctla(16'd4, 8'h0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1));
    first_seen = 1'b0;
    @(negedge clk); per_req[7] = 1'b1;
    wait_done(32'h0A);
    per_req[7] = 1'b0;
    chk("R10 fixed priority winner", first_dst, 32'h0000_D100);
    wr(12'h204, 32'h0A); wr(12'h200, 32'h0A);

    // R10 round robin: after channel 3, channel 5 beats channel 2
    wr(12'h220, 32'h1);
    rd(12'h220, d); chk("R10 global rotate bit", d, 32'h0000_000B);
    wr(12'h020, 32'h0000_0200); wr(12'h024, 32'h0000_D200); wr(12'h02C, 32'h0020_0700);
    wr(12'h050, 32'h0000_0500); wr(12'h054, 32'h0000_D500); wr(12'h05C, 32'h0020_0700);
    wr(12'h028, ctla(16'd4, 8'h0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1));
    wr(12'h058, ctla(16'd4, 8'h0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1));
    first_seen = 1'b0;
    @(negedge clk); per_req[7] = 1'b1;
    wait_done(32'h24);
    per_req[7] = 1'b0;
    chk("R10 rotating winner", first_dst, 32'h0000_D500);
    rd(12'h204, d); chk("R10 both served", d, 32'h24);

    summary();
    $finish;
  end
endmodule